// File: doc/BRIEF.md
# Maskable Priority Interrupt Controller

This block gathers interrupt requests from a timer, a disk, a network device, a software-settable pending bit and a non-maskable line. It presents at most one of them to the CPU as a single request line together with a 3-bit identity. Each maskable source has its own enable bit, and a global disable flag turns all maskable sources off together. The non-maskable line is edge-detected and held until it is acknowledged.

While a handler runs, a current priority level decides which sources may still break in: only a source more urgent than the level being serviced is presented. Acknowledging the presented request saves the current level on a small stack and raises the level to that of the acknowledged source. A return input restores the saved level, which lets handlers nest in order of urgency. Software can also write the level directly.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Sources are ranked most urgent first as NMI (ID 0), timer (ID 1), disk (ID 2), network (ID 3), software (ID 4). The most urgent eligible source is reported on `irq_id_o` and `irq_o` is high. With nothing eligible, `irq_o` is low and `irq_id_o` is 7.
- R2: `mask_wdata` bit 0 enables the timer, bit 1 the disk, bit 2 the network and bit 3 the software source (1 = enabled). The mask is written by `mask_wr`, takes effect the cycle after the write, and resets to all zero.
- R3: While the global disable flag (written by `gdis_wr` with `gdis_wdata`, reset 0) is 1, no maskable source is presented. The NMI is not affected by this flag.
- R4: `swi_set` sets the software pending bit and `swi_clr` clears it, with clear winning when both are high. The bit keeps its value until software changes it, and an acknowledge does not clear it.
- R5: A rising edge on `nmi_in` latches an NMI request. The request stays pending after `nmi_in` falls and is cleared only by an accepted acknowledge of ID 0. A new rising edge in that same cycle keeps it pending.
- R6: A source with ID i is presented only when i is less than the current level. The level resets to 7. Levels 5, 6 and 7 hold off nothing, and level 0 holds off every source, including a further NMI.
- R7: An acknowledge is accepted only while `irq_o` is high. Then the current level is pushed onto the stack and the level becomes the presented ID at the next cycle. An acknowledge while `irq_o` is low has no effect.
- R8: `ret` pops the stack into the current level. Popping an empty stack gives level 7. Pushing onto a full stack (STK_DEPTH entries) discards the oldest entry.
- R9: `lvl_wr` loads `lvl_wdata` into the current level at the next cycle. In the same cycle, an accepted acknowledge overrides `ret` and `lvl_wr`, and `ret` overrides `lvl_wr`.
- R10: The timer, disk and network request lines are level-sensitive. A change on any of them shows on `irq_o` and `irq_id_o` in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_req | input | 1 | Timer request, level-sensitive |
| disk_req | input | 1 | Disk request, level-sensitive |
| net_req | input | 1 | Network request, level-sensitive |
| nmi_in | input | 1 | Non-maskable request, rising-edge detected |
| mask_wr | input | 1 | Write strobe for the enable mask |
| mask_wdata | input | 4 | New enable mask |
| swi_set | input | 1 | Set the software pending bit |
| swi_clr | input | 1 | Clear the software pending bit |
| gdis_wr | input | 1 | Write strobe for the global disable flag |
| gdis_wdata | input | 1 | New global disable value |
| lvl_wr | input | 1 | Write strobe for the current level |
| lvl_wdata | input | 3 | New current level |
| ack | input | 1 | Acknowledge of the presented request |
| ret | input | 1 | Handler return; restores the saved level |
| irq_o | output | 1 | Request to the CPU |
| irq_id_o | output | 3 | Identity of the presented source, 7 when none |

## Verification
Device request lines affect the outputs in the same cycle. Writes to the mask, flag, software bit and level, and also acknowledge, return and an NMI edge, all act at the next clock edge, so their results show one cycle after the stimulus. The bench drives each cycle's inputs just after a rising edge. It compares the outputs with its reference model before the following edge, and only then advances the model by that edge. In this way a combinational effect is checked in its own cycle and a registered effect is checked exactly one cycle later. Directed sequences cover nesting, stack overflow and underflow, and simultaneous strobes. A long stretch with pseudo-random inputs follows them.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int STK_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       timer_req,
  input  logic       disk_req,
  input  logic       net_req,
  input  logic       nmi_in,
  input  logic       mask_wr,
  input  logic [3:0] mask_wdata,
  input  logic       swi_set,
  input  logic       swi_clr,
  input  logic       gdis_wr,
  input  logic       gdis_wdata,
  input  logic       lvl_wr,
  input  logic [2:0] lvl_wdata,
  input  logic       ack,
  input  logic       ret,
  output logic       irq_o,
  output logic [2:0] irq_id_o
);

  localparam logic [2:0] ID_NMI  = 3'd0;
  localparam logic [2:0] ID_TMR  = 3'd1;
  localparam logic [2:0] ID_DISK = 3'd2;
  localparam logic [2:0] ID_NET  = 3'd3;
  localparam logic [2:0] ID_SW   = 3'd4;
  localparam logic [2:0] ID_NONE = 3'd7;

  logic [3:0] mask_q;
  logic       gdis_q;
  logic       swi_q;
  logic       nmi_prev;
  logic       nmi_lat;
  logic [2:0] lvl_q;
  logic [2:0] stk [STK_DEPTH];

  logic       nmi_edge;
  logic [3:0] live;
  logic       take;

  assign nmi_edge = nmi_in & ~nmi_prev;
  assign live     = {swi_q, net_req, disk_req, timer_req} & mask_q & {4{~gdis_q}};
  assign take     = ack & irq_o;

  always_comb begin
    irq_o    = 1'b1;
    irq_id_o = ID_NONE;
    if (nmi_lat && lvl_q > ID_NMI)      irq_id_o = ID_NMI;
    else if (live[0] && lvl_q > ID_TMR)  irq_id_o = ID_TMR;
    else if (live[1] && lvl_q > ID_DISK) irq_id_o = ID_DISK;
    else if (live[2] && lvl_q > ID_NET)  irq_id_o = ID_NET;
    else if (live[3] && lvl_q > ID_SW)   irq_id_o = ID_SW;
    else                                 irq_o = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '0;
      gdis_q   <= 1'b0;
      swi_q    <= 1'b0;
      nmi_prev <= 1'b0;
      nmi_lat  <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= mask_wdata;
      if (gdis_wr) gdis_q <= gdis_wdata;
      if (swi_clr)      swi_q <= 1'b0;
      else if (swi_set) swi_q <= 1'b1;
      nmi_prev <= nmi_in;
      if (nmi_edge)                          nmi_lat <= 1'b1;
      else if (take && irq_id_o == ID_NMI)   nmi_lat <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= ID_NONE;
      for (int i = 0; i < STK_DEPTH; i++) stk[i] <= ID_NONE;
    end else if (take) begin
      lvl_q  <= irq_id_o;
      stk[0] <= lvl_q;
      for (int i = 1; i < STK_DEPTH; i++) stk[i] <= stk[i-1];
    end else if (ret) begin
      lvl_q <= stk[0];
      for (int i = 0; i < STK_DEPTH - 1; i++) stk[i] <= stk[i+1];
      stk[STK_DEPTH-1] <= ID_NONE;
    end else if (lvl_wr) begin
      lvl_q <= lvl_wdata;
    end
  end

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       nmi_in,
  input logic       ack,
  input logic       ret,
  input logic       irq_o,
  input logic [2:0] irq_id_o,
  input logic [3:0] mask_q,
  input logic       gdis_q,
  input logic       nmi_lat,
  input logic [2:0] lvl_q,
  input logic [2:0] stk_top
);

  a_r1_id_range: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o ? (irq_id_o < 3'd5) : (irq_id_o == 3'd7));

  a_r2_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_id_o != 3'd0) |-> mask_q[irq_id_o - 3'd1]);

  a_r3_gdis_nmi_only: assert property (@(posedge clk) disable iff (!rst_n)
    (gdis_q && irq_o) |-> (irq_id_o == 3'd0));

  a_r5_nmi_latched: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_in) |=> nmi_lat);

  a_r6_above_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_id_o < lvl_q));

  a_r7_ack_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_o) |=> (lvl_q == $past(irq_id_o)));

  a_r8_ret_restores: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !(ack && irq_o)) |=> (lvl_q == $past(stk_top)));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .ack(ack), .ret(ret),
  .irq_o(irq_o), .irq_id_o(irq_id_o), .mask_q(mask_q), .gdis_q(gdis_q),
  .nmi_lat(nmi_lat), .lvl_q(lvl_q), .stk_top(stk[0])
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic clk = 0, rst_n = 0;
  logic timer_req = 0, disk_req = 0, net_req = 0, nmi_in = 0;
  logic mask_wr = 0, swi_set = 0, swi_clr = 0, gdis_wr = 0, gdis_wdata = 0;
  logic lvl_wr = 0, ack = 0, ret = 0;
  logic [3:0] mask_wdata = 0;
  logic [2:0] lvl_wdata = 0;
  logic irq_o;
  logic [2:0] irq_id_o;

  prio_irq_ctrl #(.STK_DEPTH(DEPTH)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  int m_mask, m_gdis, m_swi, m_nmi, m_prev, m_lvl;
  int m_stk[$];

  function automatic int exp_id();
    bit [3:0] r;
    r = {m_swi[0], net_req, disk_req, timer_req} & m_mask[3:0];
    if (m_nmi && m_lvl > 0) return 0;
    if (m_gdis) return 7;
    for (int i = 0; i < 4; i++) if (r[i] && (i + 1) < m_lvl) return i + 1;
    return 7;
  endfunction

  task automatic model_reset();
    m_mask = 0; m_gdis = 0; m_swi = 0; m_nmi = 0; m_prev = 0; m_lvl = 7;
    m_stk.delete();
  endtask

  task automatic model_edge();
    int id = exp_id();
    if (ack && id != 7) begin
      m_stk.push_front(m_lvl);
      if (m_stk.size() > DEPTH) void'(m_stk.pop_back());
      m_lvl = id;
      if (id == 0) m_nmi = 0;
    end else if (ret) begin
      m_lvl = (m_stk.size() > 0) ? m_stk.pop_front() : 7;
    end else if (lvl_wr) m_lvl = lvl_wdata;
    if (nmi_in && !m_prev) m_nmi = 1;
    m_prev = nmi_in;
    if (mask_wr) m_mask = mask_wdata;
    if (gdis_wr) m_gdis = gdis_wdata;
    if (swi_clr) m_swi = 0; else if (swi_set) m_swi = 1;
  endtask

  task automatic check_now();
    int e = exp_id();
    checks++;
    if (irq_o !== (e != 7) || irq_id_o !== e[2:0]) begin
      fails++;
      $display("FAIL %s: irq=%0b id=%0d expected irq=%0b id=%0d", tag, irq_o, irq_id_o, e != 7, e);
    end
  endtask

  task automatic clear_strobes();
    mask_wr = 0; swi_set = 0; swi_clr = 0; gdis_wr = 0; lvl_wr = 0; ack = 0; ret = 0;
  endtask

  task automatic tick();
    #1 check_now();
    @(posedge clk);
    model_edge();
    #1 clear_strobes();
  endtask

  task automatic wmask(input logic [3:0] v); mask_wr = 1; mask_wdata = v; tick(); endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 tag = "R1_reset"; check_now();
    rst_n = 1;
    tag = "R2"; timer_req = 1; disk_req = 1; net_req = 1; tick(); tick();
    wmask(4'b0100); tick();
    wmask(4'b0110); tick();
    tag = "R10"; disk_req = 0; tick(); timer_req = 0; tick();
    wmask(4'b1111); timer_req = 1; tick(); timer_req = 0; tick();
    tag = "R4"; net_req = 0; swi_set = 1; tick(); tick();
    swi_set = 1; swi_clr = 1; tick(); tick();
    swi_set = 1; tick();
    ack = 1; tick(); ret = 1; tick(); tick();
    tag = "R3"; disk_req = 1; gdis_wr = 1; gdis_wdata = 1; tick(); tick();
    tag = "R5"; nmi_in = 1; tick(); nmi_in = 0; tick(); tick();
    ack = 1; tick(); tick();
    tag = "R6"; nmi_in = 1; tick(); tick(); nmi_in = 0; ret = 1; tick(); tick();
    ack = 1; tick(); tick();
    tag = "R3"; gdis_wr = 1; gdis_wdata = 0; tick();
    tag = "R7"; disk_req = 0; net_req = 0; swi_clr = 1; tick();
    ack = 1; tick(); tick();
    tag = "R8"; timer_req = 1; disk_req = 1; net_req = 1; swi_set = 1;
    lvl_wr = 1; lvl_wdata = 7; tick();
    timer_req = 0; disk_req = 0; net_req = 0; ack = 1; tick();
    net_req = 1; ack = 1; tick();
    disk_req = 1; ack = 1; tick();
    timer_req = 1; ack = 1; tick();
    nmi_in = 1; tick(); nmi_in = 0; ack = 1; tick();
    timer_req = 0; disk_req = 0; net_req = 0;
    for (int k = 0; k < 6; k++) begin ret = 1; tick(); end
    tag = "R9"; lvl_wr = 1; lvl_wdata = 3; tick(); tick();
    net_req = 1; disk_req = 1; ret = 1; lvl_wr = 1; lvl_wdata = 2; tick();
    ack = 1; ret = 1; lvl_wr = 1; lvl_wdata = 0; tick(); tick();
    lvl_wr = 1; lvl_wdata = 6; tick(); tick();
    tag = "R10";
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom;
      timer_req = r[0]; disk_req = r[1]; net_req = r[2]; nmi_in = r[3] & r[4];
      mask_wr = r[5] & r[6]; mask_wdata = r[10:7]; swi_set = r[11]; swi_clr = r[12] & r[13];
      gdis_wr = r[14] & r[15] & r[16]; gdis_wdata = r[17];
      lvl_wr = r[18] & r[19] & r[20]; lvl_wdata = r[23:21];
      ack = r[24] & r[25]; ret = r[26] & r[27];
      tick();
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule